// File: doc/BRIEF.md
# Programmable sample-rate playback sequencer

This block paces the playback of audio samples from a byte queue into a parallel DAC. Software writes a 4-bit rate code into a shadow register. A loadable up-counter advances once per base tick. When it reaches terminal count (all ones), it reloads from the shadow register. A larger code therefore gives a shorter period, so one fixed base tick covers a range of about 2 kHz to 32 kHz.

Each terminal-count reload starts a short ordered sequence, provided the queue holds data. First the DAC latches the byte at the queue head. Then, on the next system clock, the queue is told to advance. The base tick is a synchronous enable and is never used as a clock, so the whole block runs in one clock domain.

The sequencing state machine has three states:
- `ST_IDLE` waits for a reload. The transition IDLE→LATCH is taken on a reload with a non-empty queue.
- `ST_LATCH` drives the DAC load strobe. The transition LATCH→ADVANCE is unconditional.
- `ST_ADVANCE` drives the queue pop. The transition ADVANCE→IDLE is unconditional.

Base ticks must be at least three system clocks apart.

Top module: `sample_pacer`

## Requirements
- R1: After reset `dac_data` is 0, `dac_load` and `fifo_pop` are low, and the rate code and counter are 0. The first reload therefore comes on the 16th base tick.
- R2: Reloads are spaced exactly 16 − code base ticks apart, where code is the rate value in force for that period (code 15 gives one tick, code 0 gives sixteen).
- R3: A rate write changes the shadow register at once but never the period in progress. The new code is first loaded into the counter at the next reload.
- R4: On a reload with the queue non-empty, `dac_load` is high for exactly one system clock: the clock after the edge that sampled the tick. During that clock `dac_data` equals the byte that `fifo_head` presented at that edge.
- R5: `fifo_pop` is high for exactly one system clock, the one right after `dac_load`. It is never high at the same time as `dac_load` and never high without it.
- R6: On a reload while `fifo_empty` is high, neither strobe fires and `dac_data` keeps its value. Strobes resume at the first reload after data arrives.
- R7: `dac_data` changes only in a cycle where `dac_load` is high.
- R8: The period is counted in base ticks and does not depend on how many system clocks separate the ticks (three or more).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Base tick, one-clock synchronous enable |
| rate_we | input | 1 | Write strobe for the rate shadow register |
| rate_wdata | input | 4 | Rate code to write |
| fifo_head | input | 8 | Byte waiting at the queue output |
| fifo_empty | input | 1 | Queue holds no data |
| dac_data | output | 8 | Sample held for the DAC |
| dac_load | output | 1 | DAC latch strobe, one clock |
| fifo_pop | output | 1 | Queue advance strobe, one clock |

## Verification
A corrupted counter or shadow register cannot be seen until the next reload. The error then appears as a gap between DAC strobes that differs from 16 − code ticks, which is at most sixteen ticks after the fault. A wrong sequencer state appears on the very next clock, in one of three ways:
- a pop without a preceding load;
- two strobes in the same cycle;
- a DAC byte that changes outside its strobe.

The bench sweeps every rate code, varies the spacing between ticks, changes the rate in the middle of a period and drains the queue. All expected intervals and bytes are computed arithmetically.

// File: rtl/sample_pacer_pkg.sv
package sample_pacer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LATCH   = 2'd1,
        ST_ADVANCE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pacer_rate_counter.sv
module pacer_rate_counter #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic              reload
);
    localparam logic [RATE_W-1:0] TERM = {RATE_W{1'b1}};

    logic [RATE_W-1:0] shadow_q;
    logic [RATE_W-1:0] cnt_q;

    // shadow register: written any time, seen by the counter only on reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (rate_we) begin
            shadow_q <= rate_wdata;
        end
    end

    assign reload = tick_en && (cnt_q == TERM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= shadow_q;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pacer_strobe_fsm.sv
module pacer_strobe_fsm
    import sample_pacer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              fifo_empty,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_load,
    output logic              fifo_pop
);
    seq_state_e state_q, state_d;
    logic       start;

    assign start = (state_q == ST_IDLE) && reload && !fifo_empty;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (reload && !fifo_empty) state_d = ST_LATCH;
            ST_LATCH:   state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // head byte is captured as the LATCH state is entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_data <= '0;
        end else if (start) begin
            dac_data <= fifo_head;
        end
    end

    always_comb begin
        dac_load = 1'b0;
        fifo_pop = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_LATCH:   dac_load = 1'b1;
            ST_ADVANCE: fifo_pop = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer #(
    parameter int RATE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              fifo_empty,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_load,
    output logic              fifo_pop
);
    logic reload_w;

    pacer_rate_counter #(.RATE_W(RATE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .reload     (reload_w)
    );

    pacer_strobe_fsm #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload_w),
        .fifo_head  (fifo_head),
        .fifo_empty (fifo_empty),
        .dac_data   (dac_data),
        .dac_load   (dac_load),
        .fifo_pop   (fifo_pop)
    );
endmodule

// File: rtl/sample_pacer_chk.sv
module sample_pacer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reload,
    input logic              fifo_empty,
    input logic [DATA_W-1:0] dac_data,
    input logic              dac_load,
    input logic              fifo_pop
);
    // R5
    pop_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> fifo_pop);

    // R5
    pop_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(dac_load));

    // R5
    strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_load && fifo_pop));

    // R4
    load_on_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !fifo_empty && !dac_load && !fifo_pop) |=> dac_load);

    // R6
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && fifo_empty && !dac_load && !fifo_pop) |=> !dac_load);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_data) |-> dac_load);
endmodule

bind sample_pacer sample_pacer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (reload_w),
    .fifo_empty (fifo_empty),
    .dac_data   (dac_data),
    .dac_load   (dac_load),
    .fifo_pop   (fifo_pop)
);

// File: tb/sample_pacer_test.sv
`timescale 1ns/1ps
module sample_pacer_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_en;
    logic       rate_we;
    logic [3:0] rate_wdata;
    logic [7:0] fifo_head;
    logic       fifo_empty;
    logic [7:0] dac_data;
    logic       dac_load;
    logic       fifo_pop;

    int checks = 0;
    int errors = 0;
    int rd_idx = 0;
    int fill   = 0;

    always #2.5 clk = ~clk;

    assign fifo_head  = 8'(rd_idx * 37 + 11);
    assign fifo_empty = (rd_idx >= fill);

    sample_pacer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_we(rate_we),
        .rate_wdata(rate_wdata), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
        .dac_data(dac_data), .dac_load(dac_load), .fifo_pop(fifo_pop)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one base tick followed by idle cycles; gap is total clocks (>= 3)
    task automatic do_tick(input int gap, output bit strobed);
        logic [7:0] exp_byte, held;
        bit was_empty, l1, p1, l2, p2;
        @(negedge clk);
        tick_en = 1'b1;
        exp_byte = fifo_head;
        was_empty = fifo_empty;
        held = dac_data;
        @(negedge clk);
        tick_en = 1'b0;
        l1 = dac_load; p1 = fifo_pop;
        if (l1) begin
            check(dac_data == exp_byte, "R4 dac byte", dac_data, exp_byte);
            check(!was_empty, "R6 load only with data", was_empty, 0);
        end else begin
            check(dac_data == held, "R7 data held", dac_data, held);
        end
        check(!p1, "R5 no pop with load", p1, 0);
        @(negedge clk);
        l2 = dac_load; p2 = fifo_pop;
        check(!l2, "R4 load one clock", l2, 0);
        check(p2 == l1, "R5 pop after load", p2, l1);
        if (p2) rd_idx++;
        for (int k = 2; k < gap; k++) begin
            @(negedge clk);
            check(!dac_load && !fifo_pop, "R6 quiet between", dac_load, 0);
        end
        strobed = l1;
    endtask

    task automatic run_to_strobe(input int gap, output int n);
        bit s;
        n = 0;
        do begin
            do_tick(gap, s);
            n++;
        end while (!s && n < 40);
    endtask

    task automatic write_rate(input int c);
        @(negedge clk);
        rate_we = 1'b1;
        rate_wdata = 4'(c);
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int n, prev;
        bit s;
        int cnt;
        rst_n = 1'b0; tick_en = 1'b0; rate_we = 1'b0; rate_wdata = 4'd0;
        fill = 0; rd_idx = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(dac_data == 8'd0, "R1 reset data", dac_data, 0);
        check(!dac_load && !fifo_pop, "R1 reset strobes", dac_load, 0);
        rst_n = 1'b1;
        fill = 1000;

        // R1: code 0 after reset, first reload on 16th tick; R2 next period
        run_to_strobe(3, n);
        check(n == 16, "R1 first period", n, 16);
        run_to_strobe(3, n);
        check(n == 16, "R2 period code 0", n, 16);

        // sweep all codes, with varied tick spacing (R8)
        prev = 0;
        for (int c = 0; c < 16; c++) begin
            write_rate(c);
            run_to_strobe(3, n);
            check(n == 16 - prev, "R3 old period kept", n, 16 - prev);
            for (int r = 0; r < 2; r++) begin
                run_to_strobe(3 + (c % 4) + 2 * r, n);
                check(n == 16 - c, "R2 R8 period", n, 16 - c);
            end
            prev = c;
        end

        // mid-period change: code 15 in force
        write_rate(2);
        run_to_strobe(4, n);
        check(n == 1, "R3 finish code 15 period", n, 1);
        for (int k = 0; k < 5; k++) begin
            do_tick(4, s);
            check(!s, "R3 no early strobe", s, 0);
        end
        write_rate(9);
        run_to_strobe(5, n);
        check(n == 9, "R3 mid-period write ignored", n, 9);
        run_to_strobe(3, n);
        check(n == 7, "R3 new code at reload", n, 7);

        // drain: two full reloads with no data
        fill = rd_idx;
        cnt = 0;
        for (int k = 0; k < 14; k++) begin
            do_tick(3, s);
            if (s) cnt++;
        end
        check(cnt == 0, "R6 no strobes when empty", cnt, 0);
        fill = rd_idx + 4;
        run_to_strobe(3, n);
        check(n == 7, "R6 resume at reload", n, 7);
        summary();
    end
endmodule